// File: doc/BRIEF.md
# USB OTG Interrupt Aggregation Register Block

This block gathers the interrupt events of a USB OTG controller into one 32-bit source word. The events come from the transmit endpoints, the receive endpoints and the core. Software reaches the block over a simple 32-bit register bus.

Software never writes the source or mask words directly. Each word has a pair of aliases. Writing ones to the set alias raises those bits, and writing ones to the clear alias drops them. A read-only masked view shows which pending events are enabled. The set alias also lets software inject an event, for example a VBUS-drive change.

The block drives one level interrupt line. After the line has fired, it stays quiet until software writes the end-of-interrupt register. An interrupt service routine therefore acknowledges what it found, finishes its work and then re-arms the line with a single write. A control bit returns the whole block to its reset state.

Top module: `usbirq_agg`

## Requirements
- R1: After reset the revision word (offset 0x00) reads 0x4D550102, the source (0x20) and mask (0x2C) words read 0 and `irq` is low.
- R2: Source bits 4:0 hold the transmit events of endpoints 0 to 4 (`ev_tx[i]` sets bit i). Bits 12:9 hold the receive events of endpoints 1 to 4 (`ev_rx[i]` sets bit 9+i). Bits 24:16 hold the core events (`ev_core[i]` sets bit 16+i, and bit 24 is the VBUS-drive change). Every other bit, bit 8 included, always reads 0.
- R3: Writing the source-set alias (0x24) sets each source bit that is written as 1 and leaves the bits written as 0 unchanged.
- R4: Writing the source-clear alias (0x28) clears exactly the source bits that are written as 1.
- R5: When a hardware event and a software clear hit the same source bit in the same cycle, the bit ends up set.
- R6: The mask-set (0x30) and mask-clear (0x34) aliases set or clear only the mask bits written as 1. The masked view (0x38) reads source AND mask.
- R7: While the line is armed, `irq` rises one clock after the registered masked view becomes non-zero. It falls one clock after the masked view becomes zero.
- R8: Once `irq` has fallen, it stays low, even with new masked events pending, until any value is written to the end-of-interrupt register (0x3C). It rises one clock after that write takes effect if events are pending.
- R9: Writing control (0x04) with bit 0 set clears the source and mask, drops `irq` and re-arms the line. Control reads 0.
- R10: Writes to the read-only offsets (0x00, 0x08, 0x20, 0x2C, 0x38) have no effect. The aliases, the end-of-interrupt register and unmapped offsets read 0.
- R11: The status word (0x08) reads `vbus_drv` in bit 0 and 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| ev_tx | input | 5 | Transmit endpoint event pulses, endpoints 0 to 4 |
| ev_rx | input | 4 | Receive endpoint event pulses, endpoints 1 to 4 |
| ev_core | input | 9 | Core event pulses, bit 8 = VBUS-drive change |
| vbus_drv | input | 1 | Current VBUS-drive level from the core |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a hardware event that lands on a bit in the same clock as a software clear of that bit. The bench drives one event pulse in the exact cycle in which the clear write is sampled, then reads the source back to show the bit survived. The quiet period after the line falls is also hard to reach. The bench lets the line fire, acknowledges the source, raises a new masked event through the set alias and shows the line stays low. It then writes end-of-interrupt and sees the line rise.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = ADDR_W - 2;

    // word indexes (byte offset / 4)
    localparam logic [IDX_W-1:0] IDX_REV  = 6'h00;
    localparam logic [IDX_W-1:0] IDX_CTRL = 6'h01;
    localparam logic [IDX_W-1:0] IDX_STAT = 6'h02;
    localparam logic [IDX_W-1:0] IDX_SRC  = 6'h08;
    localparam logic [IDX_W-1:0] IDX_SSET = 6'h09;
    localparam logic [IDX_W-1:0] IDX_SCLR = 6'h0A;
    localparam logic [IDX_W-1:0] IDX_MSK  = 6'h0B;
    localparam logic [IDX_W-1:0] IDX_MSET = 6'h0C;
    localparam logic [IDX_W-1:0] IDX_MCLR = 6'h0D;
    localparam logic [IDX_W-1:0] IDX_MSKD = 6'h0E;
    localparam logic [IDX_W-1:0] IDX_EOI  = 6'h0F;

    localparam int TX_N     = 5;
    localparam int RX_N     = 4;
    localparam int CORE_N   = 9;
    localparam int TX_LSB   = 0;
    localparam int RX_LSB   = 9;
    localparam int CORE_LSB = 16;

    localparam logic [DATA_W-1:0] VALID_BITS =
        ((DATA_W'(1) << TX_N) - 1) << TX_LSB |
        ((DATA_W'(1) << RX_N) - 1) << RX_LSB |
        ((DATA_W'(1) << CORE_N) - 1) << CORE_LSB;

    typedef struct packed {
        logic soft_rst;
        logic src_set;
        logic src_clr;
        logic msk_set;
        logic msk_clr;
        logic eoi;
    } wr_strb_t;
endpackage

// File: rtl/usbirq_decode.sv
module usbirq_decode
    import usbirq_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] rev_val,
    input  logic [DATA_W-1:0] stat_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] msk_val,
    output wr_strb_t          strb,
    output logic [DATA_W-1:0] rdata
);
    logic [IDX_W-1:0] idx;
    logic             wr_en;

    assign idx   = bus_addr[ADDR_W-1:2];
    assign wr_en = bus_sel && bus_wr;

    always_comb begin
        strb          = '0;
        strb.soft_rst = wr_en && (idx == IDX_CTRL) && bus_wdata[0];
        strb.src_set  = wr_en && (idx == IDX_SSET);
        strb.src_clr  = wr_en && (idx == IDX_SCLR);
        strb.msk_set  = wr_en && (idx == IDX_MSET);
        strb.msk_clr  = wr_en && (idx == IDX_MCLR);
        strb.eoi      = wr_en && (idx == IDX_EOI);
    end

    always_comb begin
        rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (idx)
                IDX_REV:  rdata = rev_val;
                IDX_STAT: rdata = stat_val;
                IDX_SRC:  rdata = src_val;
                IDX_MSK:  rdata = msk_val;
                IDX_MSKD: rdata = src_val & msk_val;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/usbirq_bank.sv
module usbirq_bank #(
    parameter int               W     = 32,
    parameter logic [W-1:0]     VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [W-1:0] set_w,
    input  logic [W-1:0] clr_w,
    input  logic [W-1:0] hw_ev,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear beats set, a hardware event beats clear
        st_d.bits = (((st_q.bits | set_w) & ~clr_w) | hw_ev) & VALID;
        if (soft_clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.bits;
endmodule

// File: rtl/usbirq_gate.sv
module usbirq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic pending,
    input  logic eoi,
    output logic irq,
    output logic armed
);
    typedef struct packed {
        logic irq;
        logic armed;
    } gate_t;

    gate_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.irq   = pending && (st_q.armed || st_q.irq);
        st_d.armed = eoi ? 1'b1 : (st_q.armed && !pending);
        if (soft_clr) begin
            st_d.irq   = 1'b0;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irq   <= 1'b0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq   = st_q.irq;
    assign armed = st_q.armed;
endmodule

// File: rtl/usbirq_agg.sv
module usbirq_agg
    import usbirq_pkg::*;
#(
    parameter logic [31:0] REV_VALUE = 32'h4D55_0102
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [TX_N-1:0]      ev_tx,
    input  logic [RX_N-1:0]      ev_rx,
    input  logic [CORE_N-1:0]    ev_core,
    input  logic                 vbus_drv,
    output logic                 irq
);
    wr_strb_t          strb;
    logic [DATA_W-1:0] src_q, mask_q, hw_vec, stat_val;
    logic              armed_q, pending;

    always_comb begin
        hw_vec = '0;
        hw_vec[TX_LSB   +: TX_N]   = ev_tx;
        hw_vec[RX_LSB   +: RX_N]   = ev_rx;
        hw_vec[CORE_LSB +: CORE_N] = ev_core;
    end

    assign stat_val = {{(DATA_W-1){1'b0}}, vbus_drv};
    assign pending  = |(src_q & mask_q);

    usbirq_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .rev_val  (REV_VALUE),
        .stat_val (stat_val),
        .src_val  (src_q),
        .msk_val  (mask_q),
        .strb     (strb),
        .rdata    (bus_rdata)
    );

    usbirq_bank #(.W(DATA_W), .VALID(VALID_BITS)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_clr(strb.soft_rst),
        .set_w   (strb.src_set ? bus_wdata : '0),
        .clr_w   (strb.src_clr ? bus_wdata : '0),
        .hw_ev   (hw_vec),
        .q       (src_q)
    );

    usbirq_bank #(.W(DATA_W), .VALID(VALID_BITS)) u_msk (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_clr(strb.soft_rst),
        .set_w   (strb.msk_set ? bus_wdata : '0),
        .clr_w   (strb.msk_clr ? bus_wdata : '0),
        .hw_ev   ('0),
        .q       (mask_q)
    );

    usbirq_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_clr(strb.soft_rst),
        .pending (pending),
        .eoi     (strb.eoi),
        .irq     (irq),
        .armed   (armed_q)
    );
endmodule

// File: rtl/usbirq_agg_chk.sv
module usbirq_agg_chk
    import usbirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [TX_N-1:0]   ev_tx,
    input logic [RX_N-1:0]   ev_rx,
    input logic [CORE_N-1:0] ev_core,
    input logic              irq,
    input logic [DATA_W-1:0] src_q,
    input logic [DATA_W-1:0] mask_q,
    input logic              armed_q
);
    logic [DATA_W-1:0] hw;
    logic              soft_w, eoi_w, rd_mskd;

    always_comb begin
        hw = '0;
        hw[TX_LSB   +: TX_N]   = ev_tx;
        hw[RX_LSB   +: RX_N]   = ev_rx;
        hw[CORE_LSB +: CORE_N] = ev_core;
    end
    assign soft_w  = bus_sel && bus_wr && bus_addr == 8'h04 && bus_wdata[0];
    assign eoi_w   = bus_sel && bus_wr && bus_addr == 8'h3C;
    assign rd_mskd = bus_sel && !bus_wr && bus_addr == 8'h38;

    // R2: only defined event bits ever hold a value
    a_r2_valid_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q & ~VALID_BITS) == 0 && (mask_q & ~VALID_BITS) == 0);

    // R5: a hardware event is never lost, whatever software writes
    a_r5_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (hw != 0 && !soft_w) |=> ((src_q & $past(hw)) == $past(hw)));

    // R6: masked view on the bus
    a_r6_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mskd |-> bus_rdata == (src_q & mask_q));

    // R7: the line only rises on a masked pending event
    a_r7_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(src_q & mask_q) != 0));

    // R8: once quiet and disarmed, the line stays low without end-of-interrupt
    a_r8_quiet_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !armed_q && !eoi_w) |=> !irq);

    // R9: soft reset empties the block
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_w |=> (src_q == 0 && mask_q == 0 && !irq && armed_q));
endmodule

bind usbirq_agg usbirq_agg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ev_tx    (ev_tx),
    .ev_rx    (ev_rx),
    .ev_core  (ev_core),
    .irq      (irq),
    .src_q    (src_q),
    .mask_q   (mask_q),
    .armed_q  (armed_q)
);

// File: tb/usbirq_agg_tb.sv
module usbirq_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  ev_tx = '0;
    logic [3:0]  ev_rx = '0;
    logic [8:0]  ev_core = '0;
    logic        vbus_drv = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    usbirq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_core(ev_core),
        .vbus_drv(vbus_drv), .irq(irq)
    );

    // monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        if (bus_sel && !bus_wr) begin
            logic [31:0] e;
            string       t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read without expectation, actual %h", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: addr %h actual %h expected %h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(posedge clk); #1;
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic pulse_ev(input logic [4:0] tx, input logic [3:0] rx, input logic [8:0] core);
        @(posedge clk); #1;
        ev_tx = tx; ev_rx = rx; ev_core = core;
        @(posedge clk); #1;
        ev_tx = '0; ev_rx = '0; ev_core = '0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_irq(1'b0, "R1 irq low after reset");
        bus_read(8'h00, 32'h4D55_0102, "R1 revision");
        bus_read(8'h20, 32'h0, "R1 source zero");
        bus_read(8'h2C, 32'h0, "R1 mask zero");

        // R3 / R2 set alias fills only defined bits
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_read(8'h20, 32'h01FF_1E1F, "R2 R3 set alias valid bits");
        // R4 clear only ones
        bus_write(8'h28, 32'h0000_0F00);
        bus_read(8'h20, 32'h01FF_101F, "R4 clear selected bits");
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_read(8'h20, 32'h0, "R4 clear all");

        // R2 hardware event positions
        pulse_ev(5'h1F, 4'h0, 9'h000);
        bus_read(8'h20, 32'h0000_001F, "R2 tx events");
        bus_write(8'h28, 32'hFFFF_FFFF);
        pulse_ev(5'h00, 4'h1, 9'h100);
        bus_read(8'h20, 32'h0100_0200, "R2 rx ep1 and vbus-drive event");
        bus_write(8'h28, 32'hFFFF_FFFF);

        // R5 event and clear in the same cycle
        bus_write(8'h24, 32'h0100_0000);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h0100_0001;
        ev_core = 9'h100;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; ev_core = '0;
        bus_read(8'h20, 32'h0100_0000, "R5 event survives clear");
        bus_write(8'h28, 32'hFFFF_FFFF);

        // R6 mask aliases and masked view
        bus_write(8'h30, 32'h0000_1003);
        bus_write(8'h34, 32'h0000_0002);
        bus_read(8'h2C, 32'h0000_1001, "R6 mask set/clear");
        chk_irq(1'b0, "R7 no pending, no irq");
        bus_write(8'h24, 32'h0000_1010);
        bus_read(8'h38, 32'h0000_1000, "R6 masked view");
        chk_irq(1'b1, "R7 irq asserted");

        // R7 falls, R8 stays quiet until end-of-interrupt
        bus_write(8'h28, 32'h0000_1000);
        chk_irq(1'b0, "R7 irq falls after acknowledge");
        bus_write(8'h24, 32'h0000_0001);
        chk_irq(1'b0, "R8 quiet without eoi");
        chk_irq(1'b0, "R8 still quiet");
        bus_write(8'h3C, 32'h0);
        chk_irq(1'b1, "R8 re-armed by eoi");

        // R10 read-only and unmapped
        bus_write(8'h20, 32'h0000_0000);
        bus_write(8'h38, 32'h0000_0000);
        bus_write(8'h2C, 32'h0);
        bus_read(8'h20, 32'h0000_0011, "R10 source write ignored");
        bus_read(8'h2C, 32'h0000_1001, "R10 mask write ignored");
        bus_read(8'h24, 32'h0, "R10 alias reads zero");
        bus_read(8'h3C, 32'h0, "R10 eoi reads zero");
        bus_read(8'h40, 32'h0, "R10 unmapped reads zero");
        bus_read(8'h0C, 32'h0, "R10 gap reads zero");

        // R11 status
        vbus_drv = 1'b1;
        bus_read(8'h08, 32'h1, "R11 status high");
        vbus_drv = 1'b0;
        bus_read(8'h08, 32'h0, "R11 status low");

        // R9 soft reset
        bus_write(8'h04, 32'h1);
        bus_read(8'h20, 32'h0, "R9 source cleared");
        bus_read(8'h2C, 32'h0, "R9 mask cleared");
        bus_read(8'h04, 32'h0, "R9 control reads zero");
        chk_irq(1'b0, "R9 irq low");
        bus_write(8'h30, 32'h0000_0001);
        bus_write(8'h24, 32'h0000_0001);
        chk_irq(1'b1, "R9 line re-armed after soft reset");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d reads unmatched, expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule